// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block is the control that steers the two ALU operand multiplexers in the execute stage of a five-stage in-order pipeline. It compares the two source register numbers of the instruction now in execute against the destination register numbers of the two older instructions further down the pipe. One of those older instructions sits in the memory stage and the other in the write-back stage. For each operand it returns a 2-bit code saying where the operand should come from: the value read from the register file, the memory-stage result, or the write-back-stage result.

The unit has no clock and no state. A result is bypassed only when the producing stage actually writes a register, and never when that register is the hardwired zero register. When both older instructions target the same source register, the younger one in the memory stage wins. The destination number given to the unit is whichever field the producing instruction writes, so both register-format and immediate-format producers are covered. The multiplexers, the register file and the detection of load-use stalls are outside this block.

Top module: `operand_bypass_ctrl`

## Requirements
- R1: When no qualified match exists for an operand, its select code is 2'b00, meaning the register-file value.
- R2: Operand A (`selA`) compares against `srcRs`. It is 2'b10, meaning the memory-stage result, when `memWrEn` is 1, `memDst` is nonzero and `memDst` equals `srcRs`.
- R3: Operand B (`selB`) compares against `srcRt` under the same rule and gives 2'b10 on a memory-stage match.
- R4: An operand's code is 2'b01, meaning the write-back result, when `wbWrEn` is 1, `wbDst` is nonzero, `wbDst` equals that operand's source and no qualified memory-stage match exists.
- R5: A stage whose write-enable is 0 never causes a bypass from that stage, even when its destination matches.
- R6: A destination number of 0 never causes a bypass from any stage, even with the write-enable set.
- R7: When both stages qualify for the same source register, the code is 2'b10.
- R8: When the memory stage matches a source but does not write, a qualifying write-back match gives 2'b01.
- R9: The two codes are computed independently. When `srcRs` equals `srcRt`, both codes can select the same stage.
- R10: The code 2'b11 is never produced on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRs | input | 5 | First source register of the execute-stage instruction (operand A) |
| srcRt | input | 5 | Second source register of the execute-stage instruction (operand B) |
| memDst | input | 5 | Destination register of the memory-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| wbDst | input | 5 | Destination register of the write-back-stage instruction |
| wbWrEn | input | 1 | Write-back-stage instruction writes a register |
| selA | output | 2 | Source select for operand A: 00 register file, 10 memory stage, 01 write-back |
| selB | output | 2 | Source select for operand B, same encoding |

## Verification
Two functions can apply to the same operand at once: a memory-stage bypass and a write-back bypass. The bench provokes this by giving both stages the same destination while enabling and disabling each write flag. It judges the result against a reference that gives the memory stage priority. A sweep over a four-register subset covers every combination of matches, write flags and the zero register for both operands together, so a shared source reaching both operands is also compared.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_OPND = 2;

  typedef enum logic [1:0] {
    SEL_REG = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic [NUM_OPND-1:0] memHit;
    logic [NUM_OPND-1:0] wbHit;
  } hitStrobes_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPND-1:0][REG_W-1:0] srcReg,
  input  logic [REG_W-1:0]               memDst,
  input  logic                           memWrEn,
  input  logic [REG_W-1:0]               wbDst,
  input  logic                           wbWrEn,
  output hitStrobes_t                    hits
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic memLive;
  logic wbLive;

  assign memLive = memWrEn && (memDst != ZERO_REG);
  assign wbLive  = wbWrEn  && (wbDst  != ZERO_REG);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    assign hits.memHit[g] = memLive && (memDst == srcReg[g]);
    assign hits.wbHit[g]  = wbLive  && (wbDst  == srcReg[g]);

    always_comb begin
      // R5: a stage that does not write produces no strobe
      a_r5_mem_needs_write: assert (memWrEn || !hits.memHit[g])
        else $error("memory-stage strobe without write enable");
      a_r5_wb_needs_write: assert (wbWrEn || !hits.wbHit[g])
        else $error("write-back strobe without write enable");
      // R6: register zero never produces a strobe
      a_r6_zero_reg: assert (srcReg[g] != ZERO_REG || (!hits.memHit[g] && !hits.wbHit[g]))
        else $error("strobe raised for register zero");
    end
  end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  hitStrobes_t                hits,
  output logic [NUM_OPND-1:0][1:0]   sel
);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwdSel_e pick;

    always_comb begin
      if (hits.memHit[g])     pick = SEL_MEM;
      else if (hits.wbHit[g]) pick = SEL_WB;
      else                    pick = SEL_REG;
    end

    assign sel[g] = pick;

    always_comb begin
      // R7: the younger stage wins whenever its strobe is up
      a_r7_mem_priority: assert (!hits.memHit[g] || sel[g] == 2'b10)
        else $error("memory-stage strobe lost priority");
      // R10: code 11 is never emitted
      a_r10_no_code3: assert (sel[g] != 2'b11)
        else $error("illegal select code");
    end
  end

endmodule

// File: rtl/operand_bypass_ctrl.sv
module operand_bypass_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcRs,
  input  logic [REG_W-1:0] srcRt,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrEn,
  output logic [1:0]       selA,
  output logic [1:0]       selB
);

  logic [NUM_OPND-1:0][REG_W-1:0] srcReg;
  logic [NUM_OPND-1:0][1:0]       sel;
  hitStrobes_t                    hits;

  assign srcReg[0] = srcRs;
  assign srcReg[1] = srcRt;

  fwd_match #(.REG_W(REG_W)) u_match (
    .srcReg  (srcReg),
    .memDst  (memDst),
    .memWrEn (memWrEn),
    .wbDst   (wbDst),
    .wbWrEn  (wbWrEn),
    .hits    (hits)
  );

  fwd_select u_select (
    .hits (hits),
    .sel  (sel)
  );

  assign selA = sel[0];
  assign selB = sel[1];

  always_comb begin
    // R2: a memory-stage code on A implies a live matching writer on Rs
    a_r2_memsel_a: assert (selA != 2'b10 || (memWrEn && memDst == srcRs && memDst != '0))
      else $error("operand A memory select unjustified");
    // R3: same for B against Rt
    a_r3_memsel_b: assert (selB != 2'b10 || (memWrEn && memDst == srcRt && memDst != '0))
      else $error("operand B memory select unjustified");
    // R4: a write-back code on A implies a live matching write-back writer
    a_r4_wbsel_a: assert (selA != 2'b01 || (wbWrEn && wbDst == srcRs && wbDst != '0))
      else $error("operand A write-back select unjustified");
  end

endmodule

// File: tb/operand_bypass_ctrl_tb.sv
module operand_bypass_ctrl_tb;

  logic       clk = 1'b0;
  logic [4:0] srcRs, srcRt, memDst, wbDst;
  logic       memWrEn, wbWrEn;
  logic [1:0] selA, selB;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         done    = 1'b0;

  always #10 clk = ~clk;

  operand_bypass_ctrl u_dut (
    .srcRs(srcRs), .srcRt(srcRt), .memDst(memDst), .memWrEn(memWrEn),
    .wbDst(wbDst), .wbWrEn(wbWrEn), .selA(selA), .selB(selB)
  );

  // vector: rs, rt, memDst, memWr, wbDst, wbWr, expA, expB
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {5'd3, 5'd4, 5'd9, 1'b1, 5'd10, 1'b1, 2'b00, 2'b00},  // R1
    {5'd3, 5'd4, 5'd3, 1'b1, 5'd10, 1'b1, 2'b10, 2'b00},  // R2
    {5'd3, 5'd4, 5'd4, 1'b1, 5'd10, 1'b1, 2'b00, 2'b10},  // R3
    {5'd3, 5'd4, 5'd9, 1'b1, 5'd3,  1'b1, 2'b01, 2'b00},  // R4
    {5'd3, 5'd4, 5'd9, 1'b1, 5'd4,  1'b1, 2'b00, 2'b01},  // R4
    {5'd3, 5'd4, 5'd3, 1'b0, 5'd4,  1'b0, 2'b00, 2'b00},  // R5
    {5'd0, 5'd0, 5'd0, 1'b1, 5'd0,  1'b1, 2'b00, 2'b00},  // R6
    {5'd7, 5'd7, 5'd7, 1'b1, 5'd7,  1'b1, 2'b10, 2'b10},  // R7, R9
    {5'd7, 5'd8, 5'd7, 1'b0, 5'd7,  1'b1, 2'b01, 2'b00},  // R8
    {5'd31,5'd31,5'd31,1'b1, 5'd1,  1'b1, 2'b10, 2'b10},  // R9
    {5'd5, 5'd6, 5'd6, 1'b1, 5'd5,  1'b1, 2'b01, 2'b10},  // R9
    {5'd2, 5'd2, 5'd0, 1'b1, 5'd2,  1'b1, 2'b01, 2'b01}   // R6
  };
  localparam string VTAG [NV] = '{"R1","R2","R3","R4","R4","R5","R6","R7","R8","R9","R9","R6"};

  function automatic logic [1:0] refSel(input logic [4:0] src, input logic [4:0] md,
                                         input logic mw, input logic [4:0] wd, input logic ww);
    if (mw && md != 0 && md == src) return 2'b10;
    if (ww && wd != 0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tagOf(input logic [4:0] src, input logic [4:0] md,
                                  input logic mw, input logic [4:0] wd, input logic ww,
                                  input bit isB);
    if (src == 0 && ((mw && md == 0) || (ww && wd == 0))) return "R6";
    if (mw && md == src && ww && wd == src) return "R7";
    if (!mw && md == src && ww && wd == src) return "R8";
    if ((!mw && md == src) || (!ww && wd == src)) return "R5";
    if (mw && md == src) return isB ? "R3" : "R2";
    if (ww && wd == src) return "R4";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp,
                       input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] md,
                       input logic mw, input logic [4:0] wd, input logic ww);
    @(negedge clk);
    srcRs = rs; srcRt = rt; memDst = md; memWrEn = mw; wbDst = wd; wbWrEn = ww;
    #5;
  endtask

  initial begin
    srcRs = '0; srcRt = '0; memDst = '0; memWrEn = 1'b0; wbDst = '0; wbWrEn = 1'b0;
    #15;
    // idle state: all zero inputs select the register file (R1)
    check("R1", selA, 2'b00, "idle selA");
    check("R1", selB, 2'b00, "idle selB");

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      apply(v[25:21], v[20:16], v[15:11], v[10], v[9:5], v[4]);
      check(VTAG[i], selA, v[3:2], $sformatf("vector %0d selA", i));
      check(VTAG[i], selB, v[1:0], $sformatf("vector %0d selB", i));
    end

    // sweep over registers 0..3 with every write-flag pairing
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int f = 0; f < 4; f++) begin
              logic mw, ww;
              mw = f[1]; ww = f[0];
              apply(5'(a), 5'(b), 5'(m), mw, 5'(w), ww);
              check(tagOf(5'(a), 5'(m), mw, 5'(w), ww, 1'b0), selA,
                    refSel(5'(a), 5'(m), mw, 5'(w), ww), "sweep selA");
              check(tagOf(5'(b), 5'(m), mw, 5'(w), ww, 1'b1), selB,
                    refSel(5'(b), 5'(m), mw, 5'(w), ww), "sweep selB");
              check("R10", {1'b0, selA == 2'b11}, 2'b00, "code 11 on selA");
              check("R10", {1'b0, selB == 2'b11}, 2'b00, "code 11 on selB");
            end

    // high register number with zero-register write-back alongside (R6, R2)
    apply(5'd31, 5'd0, 5'd31, 1'b1, 5'd0, 1'b1);
    check("R2", selA, 2'b10, "r31 memory bypass");
    check("R6", selB, 2'b00, "r0 not bypassed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule